// File: doc/BRIEF.md
# Vector Accumulator with Reduce and Fold Modes

This block sums a series of equal-length vectors, one element per cycle, into an on-chip accumulator memory of `DEPTH` words. Each run is started by a one-cycle start pulse that carries the number of iterations and the mode. Each iteration then delivers one full vector. Every element arrives with a valid flag, its element index and a flag that marks the last element of the vector. Each element is added to the word at its index, so the accumulator ends up holding the element-wise sum of all the vectors.

The two modes differ only in how the first iteration treats the memory. In reduce mode the first vector replaces whatever the memory held. In fold mode every vector, including the first, is added onto the existing contents. Those contents are preloaded through a write port that works only while the block is idle. A one-cycle done pulse marks the end of a run. The result is then read out word by word through a registered read port.

Top module: `vacc_engine`

## Requirements
- R1: After reset, `busy`, `done` and `rd_valid` are all 0.
- R2: In reduce mode (`start_mode` = 0), each element of iteration 0 is written unchanged into the word at `in_idx`. Whatever that word held before is discarded.
- R3: In every later iteration, each element is added to the word at its `in_idx`. Ten iterations of all-ones vectors in reduce mode leave 10 in every word.
- R4: In fold mode (`start_mode` = 1), every element of every iteration, including iteration 0, is added onto the word at its `in_idx`. Contents preloaded beforehand therefore take part in the sum.
- R5: A preload write (`init_we`, `init_addr`, `init_data`) stores `init_data` at `init_addr` when the block is idle. A preload write issued while `busy` is 1 has no effect.
- R6: Addition is two's-complement at `DATA_W` bits and wraps on overflow. For example, 32'h7FFFFFFF + 1 gives 32'h80000000.
- R7: The cycle after the clock edge that writes the last element (`in_last` = 1) of the final iteration, `done` is 1 for exactly one cycle and `busy` is 0.
- R8: A start pulse that arrives while `busy` is 1 is ignored. This includes a pulse in the same cycle as the final element. The run keeps its original iteration count, and `busy` stays 0 after `done`.
- R9: An element with `in_valid` = 1 presented while the block is idle does not change the memory.
- R10: A read with `rd_en` = 1 returns the word at `rd_addr` on `rd_data`, with `rd_valid` = 1, in the following cycle.
- R11: A start with `start_iters` = 0 leaves `busy` at 0, gives a one-cycle `done` in the next cycle and changes no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a run when the block is idle |
| start_mode | input | 1 | 0 = reduce, 1 = fold; sampled with `start` |
| start_iters | input | CNT_W | Number of vectors in the run; sampled with `start` |
| in_valid | input | 1 | An element is present |
| in_idx | input | $clog2(DEPTH) | Element index within the vector |
| in_last | input | 1 | Last element of the current vector |
| in_data | input | DATA_W | Element value, two's complement |
| init_we | input | 1 | Preload write strobe (idle only) |
| init_addr | input | $clog2(DEPTH) | Preload word address |
| init_data | input | DATA_W | Preload value |
| rd_en | input | 1 | Read request |
| rd_addr | input | $clog2(DEPTH) | Read word address |
| rd_data | output | DATA_W | Read result, one cycle after the request |
| rd_valid | output | 1 | `rd_data` holds a read result |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the closing element write together with a new start pulse. The second pair is an accumulating write together with a preload write. The bench provokes the first by raising `start` in exactly the cycle that carries the final `in_last` element. It judges the outcome by requiring one `done` pulse, then `busy` low in the cycle after that pulse, then an unchanged read-back. It provokes the second by issuing a preload write in the middle of a run and then checking, through the read port, that the targeted word holds only the accumulated sum.

// File: rtl/vacc_pkg.sv
package vacc_pkg;
   typedef enum logic {
      MODE_REDUCE = 1'b0,
      MODE_FOLD   = 1'b1
   } acc_mode_e;
endpackage

// File: rtl/vacc_ctrl.sv
module vacc_ctrl
   import vacc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_mode,
   input  logic [CNT_W-1:0] start_iters,
   input  logic             in_valid,
   input  logic             in_last,
   output logic             busy,
   output logic             done,
   output logic             accept,
   output logic             first_pass
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic [CNT_W-1:0] iter_q, iters_q;
   acc_mode_e        mode_q;
   logic             busy_q, done_q;

   assign accept     = busy_q && in_valid;
   assign first_pass = (mode_q == MODE_REDUCE) && (iter_q == ZERO);
   assign busy       = busy_q;
   assign done       = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         iter_q  <= '0;
         iters_q <= '0;
         mode_q  <= MODE_REDUCE;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               mode_q  <= acc_mode_e'(start_mode);
               iters_q <= start_iters;
               iter_q  <= '0;
               if (start_iters == ZERO) done_q <= 1'b1;
               else                     busy_q <= 1'b1;
            end
         end else if (in_valid && in_last) begin
            iter_q <= iter_q + ONE;
            if (iter_q == iters_q - ONE) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/vacc_combine.sv
module vacc_combine #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] elem,
   input  logic              bypass,
   output logic [DATA_W-1:0] result
);
   logic [DATA_W-1:0] sum;
   assign sum    = acc_in + elem;
   assign result = bypass ? elem : sum;
endmodule

// File: rtl/vacc_store.sv
module vacc_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  aaddr,
   output logic [DATA_W-1:0] adata,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);
   logic [DATA_W-1:0] word_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (we && (waddr == IDX_W'(g))) word_q[g] <= wdata;
      end
   end

   assign adata = word_q[aaddr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= word_q[rd_addr];
      end
   end
endmodule

// File: rtl/vacc_engine.sv
module vacc_engine #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_mode,
   input  logic [CNT_W-1:0]  start_iters,
   input  logic              in_valid,
   input  logic [IDX_W-1:0]  in_idx,
   input  logic              in_last,
   input  logic [DATA_W-1:0] in_data,
   input  logic              init_we,
   input  logic [IDX_W-1:0]  init_addr,
   input  logic [DATA_W-1:0] init_data,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              busy,
   output logic              done
);
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("vacc_engine: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("vacc_engine: DATA_W must be at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("vacc_engine: CNT_W must be at least 1");
   end

   logic              accept, first_pass;
   logic [DATA_W-1:0] acc_word, acc_next;
   logic              mem_we;
   logic [IDX_W-1:0]  mem_addr;
   logic [DATA_W-1:0] mem_wdata;

   vacc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_mode (start_mode),
      .start_iters(start_iters),
      .in_valid   (in_valid),
      .in_last    (in_last),
      .busy       (busy),
      .done       (done),
      .accept     (accept),
      .first_pass (first_pass)
   );

   vacc_combine #(.DATA_W(DATA_W)) u_comb (
      .acc_in(acc_word),
      .elem  (in_data),
      .bypass(first_pass),
      .result(acc_next)
   );

   always_comb begin
      if (busy) begin
         mem_we    = accept;
         mem_addr  = in_idx;
         mem_wdata = acc_next;
      end else begin
         mem_we    = init_we;
         mem_addr  = init_addr;
         mem_wdata = init_data;
      end
   end

   vacc_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (mem_we),
      .waddr   (mem_addr),
      .wdata   (mem_wdata),
      .aaddr   (in_idx),
      .adata   (acc_word),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .rd_valid(rd_valid)
   );
endmodule

module vacc_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic [CNT_W-1:0] start_iters,
   input logic             in_valid,
   input logic             in_last,
   input logic             busy,
   input logic             done,
   input logic             rd_en,
   input logic             rd_valid
);
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                                // R7
   AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy && in_valid && in_last) ||
                $past(!busy && start && (start_iters == '0))));      // R11
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(in_valid && in_last)) |=> busy);                    // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !busy);                                  // R9
   AST_RD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);                                           // R10
   AST_RD_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);                                         // R10
endmodule

bind vacc_engine vacc_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .start_iters(start_iters),
   .in_valid   (in_valid),
   .in_last    (in_last),
   .busy       (busy),
   .done       (done),
   .rd_en      (rd_en),
   .rd_valid   (rd_valid)
);

// File: tb/sim_vacc_engine.sv
module sim_vacc_engine;
   localparam int DW = 32, DP = 16, CW = 16, IW = 4;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          start = 0, start_mode = 0;
   logic [CW-1:0] start_iters = '0;
   logic          in_valid = 0, in_last = 0;
   logic [IW-1:0] in_idx = '0;
   logic [DW-1:0] in_data = '0;
   logic          init_we = 0;
   logic [IW-1:0] init_addr = '0;
   logic [DW-1:0] init_data = '0;
   logic          rd_en = 0;
   logic [IW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          rd_valid, busy, done;

   int checks = 0, fails = 0;
   int model [DP];
   int exp_q [$];
   string tag_q [$];

   always #2 clk = ~clk;

   vacc_engine #(.DATA_W(DW), .DEPTH(DP), .CNT_W(CW)) u0 (.*);

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: pops expected read results as rd_valid appears
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) check("R10 unexpected read", 1, 0);
         else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
   end

   task automatic read_all(input string req);
      for (int e = 0; e < DP; e++) begin
         rd_en = 1; rd_addr = IW'(e);
         exp_q.push_back(model[e]); tag_q.push_back(req);
         @(negedge clk);
      end
      rd_en = 0;
      @(negedge clk);
   endtask

   task automatic preload(input int a, input int d);
      init_we = 1; init_addr = IW'(a); init_data = d;
      @(negedge clk);
      init_we = 0;
      model[a] = d;
   endtask

   function automatic int vec(input int pat, input int it, input int e);
      if (pat == 0) return 1;
      return it * 3 - e * 5 + 2;
   endfunction

   task automatic run(input bit mode, input int iters, input int pat, input bit intrude);
      start = 1; start_mode = mode; start_iters = CW'(iters);
      @(negedge clk);
      start = 0;
      check("R8 busy after start", busy, 1);
      for (int it = 0; it < iters; it++) begin
         for (int e = 0; e < DP; e++) begin
            int ix = (pat == 1) ? DP - 1 - e : e;
            int d = vec(pat, it, ix);
            in_valid = 1; in_idx = IW'(ix); in_last = (e == DP - 1); in_data = d;
            if (intrude && it == 1 && e == 4) begin
               start = 1; start_mode = 1; start_iters = 3;
               init_we = 1; init_addr = 3; init_data = 999;
            end
            if (intrude && it == iters - 1 && e == DP - 1) begin
               start = 1; start_mode = 0; start_iters = 2;
            end
            if (mode == 0 && it == 0) model[ix] = d;
            else model[ix] = model[ix] + d;
            @(negedge clk);
            start = 0; init_we = 0;
         end
      end
      in_valid = 0; in_last = 0;
      check("R7 done after final element", done, 1);
      check("R7 busy low at done", busy, 0);
      @(negedge clk);
      check("R7 done single cycle", done, 0);
      check("R8 start ignored while busy", busy, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      check("watchdog expired", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 rd_valid", rd_valid, 0);
      rst_n = 1;
      @(negedge clk);
      // R2/R3: garbage preload overwritten, ten all-ones vectors give 10
      for (int a = 0; a < DP; a++) preload(a, 77 + a);
      run(0, 10, 0, 1);
      for (int a = 0; a < DP; a++) check("R3 model is ten", model[a], 10);
      read_all("R2/R3/R5 reduce result");
      // R4: fold onto signed preload, reversed index order
      for (int a = 0; a < DP; a++) preload(a, a * 100 - 750);
      run(1, 3, 1, 0);
      read_all("R4 fold result");
      // R2: reduce with non-uniform data overwrites R4 result
      run(0, 4, 2, 0);
      read_all("R2 reduce patterned");
      // R6: wrap
      preload(0, 32'h7FFFFFFF);
      preload(1, -1);
      run(1, 1, 0, 0);
      check("R6 model wrap", model[0], 32'h80000000);
      read_all("R6 wrap");
      // R9: elements while idle
      for (int e = 0; e < DP; e++) begin
         in_valid = 1; in_idx = IW'(e); in_last = (e == DP - 1); in_data = 5;
         @(negedge clk);
      end
      in_valid = 0; in_last = 0;
      check("R9 still idle", busy, 0);
      read_all("R9 idle elements ignored");
      // R11: zero iterations
      start = 1; start_mode = 1; start_iters = 0;
      @(negedge clk);
      start = 0;
      check("R11 done pulse", done, 1);
      check("R11 not busy", busy, 0);
      @(negedge clk);
      check("R11 done clears", done, 0);
      read_all("R11 memory unchanged");
      repeat (3) @(negedge clk);
      check("R10 queue drained", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule